// File: doc/BRIEF.md
# Target Address Channel Decoder

This block turns a system address into a memory channel number and a channel-local address. Software first loads a small table of address windows (base, limit and a control word per window) and a per-channel, per-window offset table through a register-write port. Each address presented on the request port is then matched against the windows, and the selected window's interleave settings yield the channel and the address inside that channel. Any inconsistency found on the way is reported as a failure code instead of a result.

The datapath has three registered stages: window match, channel selection with table checks, and channel address arithmetic. Results leave on a valid/ready port; a stalled output holds the whole pipeline. Interleave ways are restricted to powers of two so that every division is a shift; three-way channel interleave is recognised and refused. The tables must not be rewritten while requests are in flight.

Top module: `tad_chan_decoder`

## Requirements
- R1: The lowest-numbered enabled window with base <= address < limit is selected; if no enabled window contains the address the failure code is 1 (no window).
- R2: A selected window whose channel-way field is 3 fails with code 2, ahead of every later check.
- R3: A socket-way field outside {1,2,4,8} or a channel-way field outside {1,2,4} (other than 3) fails with code 3.
- R4: The channel index begins as address >> 6, is shifted right by one more bit when the window's shift-up flag is set, and is then divided by the socket ways.
- R5: When the window's hash flag is set, the eight 2-bit address fields starting at bits 12, 14, 16, 18, 20, 22, 24 and 26 are each XORed into the index before reduction.
- R6: The index is reduced modulo the channel ways; an index not below the window's target count fails with code 4, otherwise the channel is the target field at that index.
- R7: A target channel not below the channel count fails with code 5; a channel/window pair whose offset was never written fails with code 6.
- R8: Granularity codes map to shifts: 0 (64 B) to 6, or 7 when the shift-up flag is set; 1 (256 B) to 8; 2 (4 KB) to 12; 3 (1 GB) to 30. Socket and channel granularities are mapped independently.
- R9: The channel address subtracts the offset (code 7 if the offset exceeds the address), shifts right by the socket shift, divides by the socket ways, shifts back and ORs in the original address bits below the socket shift; it then repeats this with the channel shift and channel ways.
- R10: A result with code 0 is a success; any nonzero code returns channel 0 and channel address 0.
- R11: An accepted request appears at the output three cycles later when the output is not stalled; while out_valid_o is high and out_ready_i low, the outputs hold and in_ready_o is low.
- R12: After reset no output is valid, every window is disabled and no offset is marked written.
- R13: A write selects the table with cfg_field_i: 0 base, 1 limit, 2 control, 3 offset (of channel cfg_chan_i). Control word bits: 0 enable, 1 shift-up, 2 hash, 6:3 socket ways, 9:7 channel ways, 11:10 socket granularity, 13:12 channel granularity, 16:14 target count, and target k (3 bits) at bit 17+3k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_field_i | input | 2 | Table selector |
| cfg_rule_i | input | RULE_W | Window number written |
| cfg_chan_i | input | CHAN_W | Channel for offset writes |
| cfg_wdata_i | input | ADDR_W | Write data |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Request accepted this cycle |
| in_addr_i | input | ADDR_W | System address |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Result taken |
| out_fail_o | output | 4 | Failure code, 0 on success |
| out_chan_o | output | CHAN_W | Channel number |
| out_chan_addr_o | output | ADDR_W | Channel-local address |

## Verification
The assertions watch the output handshake on every cycle: held results under stall, refusal of new requests while stalled, the fixed three-cycle latency through an unstalled pipe, and the zeroed channel and address that accompany any failure code. Which window wins, how the shift-up, hash and granularity settings shape the channel and address, and which failure is reported for a given bad table entry depend on the table contents, so only the bench's programmed windows and its mix of directed and pseudo-random addresses, compared against a behavioural model, show them.

// File: rtl/tad_dec_pkg.sv
package tad_dec_pkg;

  localparam int TGT_N  = 4;
  localparam int TGT_W  = 3;
  localparam int TIDX_W = $clog2(TGT_N);

  typedef enum logic [3:0] {
    FAIL_NONE      = 4'd0,
    FAIL_NO_RULE   = 4'd1,
    FAIL_THREE_WAY = 4'd2,
    FAIL_BAD_WAYS  = 4'd3,
    FAIL_TGT_IDX   = 4'd4,
    FAIL_BAD_CHAN  = 4'd5,
    FAIL_NO_OFFSET = 4'd6,
    FAIL_UNDERFLOW = 4'd7
  } fail_e;

  // packed MSB first: en lands at bit 0
  typedef struct packed {
    logic [TGT_N-1:0][TGT_W-1:0] tgt;
    logic [2:0]                  ntgt;
    logic [1:0]                  cgran;
    logic [1:0]                  sgran;
    logic [2:0]                  cway;
    logic [3:0]                  sway;
    logic                        hash;
    logic                        cshift;
    logic                        en;
  } rule_ctrl_t;

  localparam int CTRL_W = $bits(rule_ctrl_t);

  function automatic logic [4:0] gran_shift(input logic [1:0] g, input logic cs);
    case (g)
      2'd0:    return cs ? 5'd7 : 5'd6;
      2'd1:    return 5'd8;
      2'd2:    return 5'd12;
      default: return 5'd30;
    endcase
  endfunction

endpackage

// File: rtl/tad_rule_match.sv
module tad_rule_match #(
  parameter int ADDR_W    = 40,
  parameter int NUM_RULES = 12,
  parameter int RULE_W    = $clog2(NUM_RULES)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i  [NUM_RULES],
  input  logic [ADDR_W-1:0] limit_i [NUM_RULES],
  input  logic [NUM_RULES-1:0] en_i,
  output logic              hit_o,
  output logic [RULE_W-1:0] rule_o
);

  logic [NUM_RULES-1:0] in_win;

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_win
    assign in_win[g] = en_i[g] && (addr_i >= base_i[g]) && (addr_i < limit_i[g]);
  end

  // scan downward so the lowest index wins
  always_comb begin
    hit_o  = 1'b0;
    rule_o = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (in_win[i]) begin
        hit_o  = 1'b1;
        rule_o = RULE_W'(i);
      end
    end
  end

endmodule

// File: rtl/tad_chan_index.sv
module tad_chan_index
  import tad_dec_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  rule_ctrl_t        ctrl_i,
  output fail_e             fail_o,
  output logic [TIDX_W-1:0] tidx_o,
  output logic [1:0]        lsw_o,
  output logic [1:0]        lcw_o
);

  localparam int HASH_FIELDS = 8;
  localparam int HASH_LSB    = 12;

  logic              sw_ok, cw_ok;
  logic [ADDR_W-1:0] sh;
  logic [1:0]        hsh;
  logic [TIDX_W-1:0] fold, mask;

  always_comb begin
    sw_ok = 1'b1;
    cw_ok = 1'b1;
    lsw_o = 2'd0;
    lcw_o = 2'd0;
    case (ctrl_i.sway)
      4'd1:    lsw_o = 2'd0;
      4'd2:    lsw_o = 2'd1;
      4'd4:    lsw_o = 2'd2;
      4'd8:    lsw_o = 2'd3;
      default: sw_ok = 1'b0;
    endcase
    case (ctrl_i.cway)
      3'd1:    lcw_o = 2'd0;
      3'd2:    lcw_o = 2'd1;
      3'd4:    lcw_o = 2'd2;
      default: cw_ok = 1'b0;
    endcase

    if (ctrl_i.cway == 3'd3)   fail_o = FAIL_THREE_WAY;
    else if (!sw_ok || !cw_ok) fail_o = FAIL_BAD_WAYS;
    else                       fail_o = FAIL_NONE;

    sh = addr_i >> 6;
    if (ctrl_i.cshift) sh = sh >> 1;
    sh = sh >> lsw_o;

    hsh = '0;
    for (int k = 0; k < HASH_FIELDS; k++) hsh ^= addr_i[HASH_LSB + 2*k +: 2];

    fold = ctrl_i.hash ? (sh[TIDX_W-1:0] ^ TIDX_W'(hsh)) : sh[TIDX_W-1:0];

    case (lcw_o)
      2'd0:    mask = TIDX_W'(0);
      2'd1:    mask = TIDX_W'(1);
      default: mask = TIDX_W'(3);
    endcase
    tidx_o = fold & mask;
  end

endmodule

// File: rtl/tad_chan_addr.sv
module tad_chan_addr
  import tad_dec_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic [4:0]        ss_i,
  input  logic [4:0]        cs_i,
  input  logic [1:0]        lsw_i,
  input  logic [1:0]        lcw_i,
  input  fail_e             fail_i,
  output fail_e             fail_o,
  output logic [ADDR_W-1:0] caddr_o
);

  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] diff, m_s, m_c, st_s, st_c;

  always_comb begin
    diff = addr_i - off_i;
    m_s  = (ONE << ss_i) - ONE;
    m_c  = (ONE << cs_i) - ONE;
    st_s = (((diff >> ss_i) >> lsw_i) << ss_i) | (addr_i & m_s);
    st_c = (((st_s >> cs_i) >> lcw_i) << cs_i) | (addr_i & m_c);

    if (fail_i != FAIL_NONE)  fail_o = fail_i;
    else if (off_i > addr_i)  fail_o = FAIL_UNDERFLOW;
    else                      fail_o = FAIL_NONE;

    caddr_o = (fail_o == FAIL_NONE) ? st_c : '0;
  end

endmodule

// File: rtl/tad_chan_decoder.sv
module tad_chan_decoder
  import tad_dec_pkg::*;
#(
  parameter  int ADDR_W    = 40,
  parameter  int NUM_RULES = 12,
  parameter  int NUM_CHAN  = 4,
  localparam int RULE_W    = $clog2(NUM_RULES),
  localparam int CHAN_W    = $clog2(NUM_CHAN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_field_i,
  input  logic [RULE_W-1:0] cfg_rule_i,
  input  logic [CHAN_W-1:0] cfg_chan_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [ADDR_W-1:0] in_addr_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [3:0]        out_fail_o,
  output logic [CHAN_W-1:0] out_chan_o,
  output logic [ADDR_W-1:0] out_chan_addr_o
);

  // ---------------- tables ----------------
  logic [ADDR_W-1:0]    base_q  [NUM_RULES];
  logic [ADDR_W-1:0]    limit_q [NUM_RULES];
  rule_ctrl_t           ctrl_q  [NUM_RULES];
  logic [ADDR_W-1:0]    off_q   [NUM_CHAN][NUM_RULES];
  logic [NUM_RULES-1:0] offv_q  [NUM_CHAN];
  logic [NUM_RULES-1:0] en_vec;

  for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
    assign en_vec[r] = ctrl_q[r].en;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[r]  <= '0;
        limit_q[r] <= '0;
        ctrl_q[r]  <= '0;
      end else if (cfg_we_i && int'(cfg_rule_i) == r) begin
        case (cfg_field_i)
          2'd0:    base_q[r]  <= cfg_wdata_i;
          2'd1:    limit_q[r] <= cfg_wdata_i;
          2'd2:    ctrl_q[r]  <= rule_ctrl_t'(cfg_wdata_i[CTRL_W-1:0]);
          default: ;
        endcase
      end
    end

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_off
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          off_q[c][r]  <= '0;
          offv_q[c][r] <= 1'b0;
        end else if (cfg_we_i && cfg_field_i == 2'd3 &&
                     int'(cfg_rule_i) == r && int'(cfg_chan_i) == c) begin
          off_q[c][r]  <= cfg_wdata_i;
          offv_q[c][r] <= 1'b1;
        end
      end
    end
  end

  // ---------------- pipeline control ----------------
  logic v1_q, v2_q, v3_q, adv;
  assign adv        = !v3_q || out_ready_i;
  assign in_ready_o = adv;

  // ---------------- stage 1: window match ----------------
  logic              hit_d, hit1_q;
  logic [RULE_W-1:0] rule_d, rule1_q;
  logic [ADDR_W-1:0] addr1_q;

  tad_rule_match #(.ADDR_W(ADDR_W), .NUM_RULES(NUM_RULES), .RULE_W(RULE_W)) u_match (
    .addr_i  (in_addr_i),
    .base_i  (base_q),
    .limit_i (limit_q),
    .en_i    (en_vec),
    .hit_o   (hit_d),
    .rule_o  (rule_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q    <= 1'b0;
      hit1_q  <= 1'b0;
      rule1_q <= '0;
      addr1_q <= '0;
    end else if (adv) begin
      v1_q    <= in_valid_i;
      hit1_q  <= hit_d;
      rule1_q <= rule_d;
      addr1_q <= in_addr_i;
    end
  end

  // ---------------- stage 2: channel select ----------------
  rule_ctrl_t        c2;
  fail_e             idx_fail, fail2_d, fail2_q;
  logic [TIDX_W-1:0] tidx;
  logic [1:0]        lsw, lcw, lsw2_q, lcw2_q;
  logic [TGT_W-1:0]  tgt;
  logic [CHAN_W-1:0] chan2_q;
  logic [ADDR_W-1:0] off2_d, off2_q, addr2_q;
  logic [4:0]        ss2_q, cs2_q;

  assign c2 = ctrl_q[rule1_q];

  tad_chan_index #(.ADDR_W(ADDR_W)) u_index (
    .addr_i (addr1_q),
    .ctrl_i (c2),
    .fail_o (idx_fail),
    .tidx_o (tidx),
    .lsw_o  (lsw),
    .lcw_o  (lcw)
  );

  always_comb begin
    tgt    = c2.tgt[tidx];
    off2_d = '0;
    if (!hit1_q)                          fail2_d = FAIL_NO_RULE;
    else if (idx_fail != FAIL_NONE)       fail2_d = idx_fail;
    else if ({1'b0, tidx} >= c2.ntgt)     fail2_d = FAIL_TGT_IDX;
    else if (int'(tgt) >= NUM_CHAN)       fail2_d = FAIL_BAD_CHAN;
    else if (!offv_q[tgt[CHAN_W-1:0]][rule1_q]) fail2_d = FAIL_NO_OFFSET;
    else begin
      fail2_d = FAIL_NONE;
      off2_d  = off_q[tgt[CHAN_W-1:0]][rule1_q];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v2_q    <= 1'b0;
      fail2_q <= FAIL_NONE;
      chan2_q <= '0;
      off2_q  <= '0;
      addr2_q <= '0;
      ss2_q   <= '0;
      cs2_q   <= '0;
      lsw2_q  <= '0;
      lcw2_q  <= '0;
    end else if (adv) begin
      v2_q    <= v1_q;
      fail2_q <= fail2_d;
      chan2_q <= (fail2_d == FAIL_NONE) ? tgt[CHAN_W-1:0] : '0;
      off2_q  <= off2_d;
      addr2_q <= addr1_q;
      ss2_q   <= gran_shift(c2.sgran, c2.cshift);
      cs2_q   <= gran_shift(c2.cgran, c2.cshift);
      lsw2_q  <= lsw;
      lcw2_q  <= lcw;
    end
  end

  // ---------------- stage 3: channel address ----------------
  fail_e             fail3_d, fail3_q;
  logic [ADDR_W-1:0] caddr_d, caddr3_q;
  logic [CHAN_W-1:0] chan3_q;

  tad_chan_addr #(.ADDR_W(ADDR_W)) u_caddr (
    .addr_i  (addr2_q),
    .off_i   (off2_q),
    .ss_i    (ss2_q),
    .cs_i    (cs2_q),
    .lsw_i   (lsw2_q),
    .lcw_i   (lcw2_q),
    .fail_i  (fail2_q),
    .fail_o  (fail3_d),
    .caddr_o (caddr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v3_q     <= 1'b0;
      fail3_q  <= FAIL_NONE;
      chan3_q  <= '0;
      caddr3_q <= '0;
    end else if (adv) begin
      v3_q     <= v2_q;
      fail3_q  <= fail3_d;
      chan3_q  <= (fail3_d == FAIL_NONE) ? chan2_q : '0;
      caddr3_q <= caddr_d;
    end
  end

  assign out_valid_o     = v3_q;
  assign out_fail_o      = fail3_q;
  assign out_chan_o      = chan3_q;
  assign out_chan_addr_o = caddr3_q;

endmodule

// File: rtl/tad_chan_decoder_sva.sv
module tad_chan_decoder_sva #(
  parameter int ADDR_W = 40,
  parameter int CHAN_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [3:0]        out_fail_o,
  input logic [CHAN_W-1:0] out_chan_o,
  input logic [ADDR_W-1:0] out_chan_addr_o
);

  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               warm_q <= '0;
    else if (warm_q != 2'd3)   warm_q <= warm_q + 2'd1;
  end

  a_r10_fail_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_fail_o != 4'd0) |-> (out_chan_o == '0 && out_chan_addr_o == '0));

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_fail_o) && $stable(out_chan_o) && $stable(out_chan_addr_o)));

  a_r11_stall_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  a_r11_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && $past(in_valid_i && in_ready_o, 3) &&
     $past(in_ready_o, 2) && $past(in_ready_o, 1)) |-> out_valid_o);

endmodule

bind tad_chan_decoder tad_chan_decoder_sva #(.ADDR_W(ADDR_W), .CHAN_W(CHAN_W)) u_sva (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .in_valid_i      (in_valid_i),
  .in_ready_o      (in_ready_o),
  .out_valid_o     (out_valid_o),
  .out_ready_i     (out_ready_i),
  .out_fail_o      (out_fail_o),
  .out_chan_o      (out_chan_o),
  .out_chan_addr_o (out_chan_addr_o)
);

// File: tb/tad_chan_decoder_bench.sv
module tad_chan_decoder_bench;

  localparam int AW = 40;
  localparam int NR = 12;
  localparam int NC = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [1:0]    cfg_field_i = '0;
  logic [3:0]    cfg_rule_i = '0;
  logic [1:0]    cfg_chan_i = '0;
  logic [AW-1:0] cfg_wdata_i = '0;
  logic          in_valid_i = 1'b0;
  logic          in_ready_o;
  logic [AW-1:0] in_addr_i = '0;
  logic          out_valid_o;
  logic          out_ready_i = 1'b0;
  logic [3:0]    out_fail_o;
  logic [1:0]    out_chan_o;
  logic [AW-1:0] out_chan_addr_o;

  always #4 clk_i = ~clk_i;

  tad_chan_decoder u_tad_chan_decoder (.*);

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural model state
  longint unsigned m_base [NR];
  longint unsigned m_lim  [NR];
  logic [AW-1:0]   m_ctrl [NR];
  longint unsigned m_off  [NC][NR];
  bit              m_offv [NC][NR];
  logic [45:0]     expq [$];

  bit            prev_stall = 0;
  logic [45:0]   prev_out;
  bit            popped;

  function automatic string tag_of(int code);
    case (code)
      0: return "R9";  1: return "R1";  2: return "R2";  3: return "R3";
      4: return "R6";  5: return "R7";  6: return "R7";  default: return "R9";
    endcase
  endfunction

  function automatic int gsh(int g, bit cs);
    case (g)
      0: return cs ? 7 : 6;
      1: return 8;
      2: return 12;
      default: return 30;
    endcase
  endfunction

  function automatic logic [45:0] model(longint unsigned a);
    int r = -1;
    logic [AW-1:0] c;
    longint unsigned idx, off, ca, sw, cw, ch;
    int ss, cs;
    for (int i = 0; i < NR; i++)
      if (r < 0 && m_ctrl[i][0] && a >= m_base[i] && a < m_lim[i]) r = i;
    if (r < 0) return {4'd1, 2'd0, 40'd0};
    c  = m_ctrl[r];
    sw = longint'(c[6:3]);
    cw = longint'(c[9:7]);
    if (cw == 3) return {4'd2, 2'd0, 40'd0};
    if (!(sw == 1 || sw == 2 || sw == 4 || sw == 8) || !(cw == 1 || cw == 2 || cw == 4))
      return {4'd3, 2'd0, 40'd0};
    idx = a >> 6;
    if (c[1]) idx = idx >> 1;
    idx = idx / sw;
    if (c[2]) for (int i = 12; i < 28; i += 2) idx = idx ^ ((a >> i) & 3);
    idx = idx % cw;
    if (idx >= longint'(c[16:14])) return {4'd4, 2'd0, 40'd0};
    ch = (longint'(c) >> (17 + 3 * idx)) & 7;
    if (ch >= NC) return {4'd5, 2'd0, 40'd0};
    if (!m_offv[ch][r]) return {4'd6, 2'd0, 40'd0};
    off = m_off[ch][r];
    if (off > a) return {4'd7, 2'd0, 40'd0};
    ss = gsh(int'(c[11:10]), c[1]);
    cs = gsh(int'(c[13:12]), c[1]);
    ca = a - off;
    ca = (((ca >> ss) / sw) << ss) | (a & ((64'd1 << ss) - 1));
    ca = (((ca >> cs) / cw) << cs) | (a & ((64'd1 << cs) - 1));
    return {4'd0, ch[1:0], ca[39:0]};
  endfunction

  function automatic logic [AW-1:0] mk(bit en, bit sh, bit hs, int sw, int cw, int sg, int cg,
                                       int nt, int t0, int t1, int t2, int t3);
    logic [AW-1:0] v = '0;
    v[0] = en; v[1] = sh; v[2] = hs;
    v[6:3] = 4'(sw); v[9:7] = 3'(cw); v[11:10] = 2'(sg); v[13:12] = 2'(cg);
    v[16:14] = 3'(nt);
    v[19:17] = 3'(t0); v[22:20] = 3'(t1); v[25:23] = 3'(t2); v[28:26] = 3'(t3);
    return v;
  endfunction

  task automatic check(string req, longint unsigned act, longint unsigned exp, string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // R13: field 0 base, 1 limit, 2 control, 3 offset
  task automatic cfg(int field, int rule, int chan, longint unsigned data);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_field_i = 2'(field); cfg_rule_i = 4'(rule);
    cfg_chan_i = 2'(chan); cfg_wdata_i = AW'(data);
    case (field)
      0: m_base[rule] = data;
      1: m_lim[rule]  = data;
      2: m_ctrl[rule] = AW'(data);
      default: begin m_off[chan][rule] = data; m_offv[chan][rule] = 1; end
    endcase
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic rule(int r, longint unsigned b, longint unsigned l, logic [AW-1:0] c);
    cfg(0, r, 0, b); cfg(1, r, 0, l); cfg(2, r, 0, longint'(c));
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(bit v, longint unsigned a, bit rdy);
    logic [45:0] e, cur;
    in_valid_i = v; in_addr_i = AW'(a); out_ready_i = rdy;
    popped = 0;
    #1;
    cur = {out_fail_o, out_chan_o, out_chan_addr_o};
    if (prev_stall) begin
      check("R11", out_valid_o, 1, "valid held under stall");
      check("R11", cur, prev_out, "outputs held under stall");
    end
    if (out_valid_o && !rdy) check("R11", in_ready_o, 0, "ready low while stalled");
    if (v && in_ready_o) expq.push_back(model(a));
    if (out_valid_o && rdy) begin
      popped = 1;
      if (expq.size() == 0) check("R11", 1, 0, "output without request");
      else begin
        e = expq.pop_front();
        check(tag_of(int'(e[45:42])), cur[45:42], e[45:42], "fail code");
        check(e[45:42] != 0 ? "R10" : "R6", cur[41:40], e[41:40], "channel");
        check(e[45:42] != 0 ? "R10" : "R9", cur[39:0], e[39:0], "channel address");
      end
    end
    prev_stall = out_valid_o && !rdy;
    prev_out   = cur;
    @(negedge clk_i);
  endtask

  task automatic single(longint unsigned a);
    int n = 0;
    step(1, a, 1);
    do begin step(0, 0, 1); n++; end while (!popped && n < 10);
    check("R11", n, 3, "latency");
  endtask

  initial begin
    logic [31:0] lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < NR; i++) begin
      m_base[i] = 0; m_lim[i] = 0; m_ctrl[i] = '0;
      for (int c = 0; c < NC; c++) begin m_off[c][i] = 0; m_offv[c][i] = 0; end
    end
    repeat (4) @(negedge clk_i);
    // R12: reset state
    check("R12", out_valid_o, 0, "valid in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R12", out_valid_o, 0, "valid after reset");
    check("R12", in_ready_o, 1, "ready after reset");
    single(40'h0000_1000); // R12: every window disabled -> no window

    rule(0, 64'h0, 64'h10_0000, mk(1,0,0,1,2,0,0,2,0,1,0,0));
    cfg(3, 0, 0, 0); cfg(3, 0, 1, 0);
    rule(1, 64'h10_0000, 64'h1000_0000, mk(1,1,1,2,4,2,1,4,3,2,1,0));
    cfg(3, 1, 0, 64'h10_0000); cfg(3, 1, 1, 64'h10_0000); cfg(3, 1, 3, 64'h10_0000);
    rule(2, 64'h1000_0000, 64'h2000_0000, mk(1,0,0,1,3,0,0,3,0,1,2,0));
    rule(3, 64'h2000_0000, 64'h3000_0000, mk(1,0,0,3,1,0,0,1,0,0,0,0));
    rule(4, 64'h3000_0000, 64'h4000_0000, mk(1,0,0,1,4,0,0,2,5,1,0,0));
    cfg(3, 4, 1, 0);
    rule(5, 64'h4000_0000, 64'h8000_0000, mk(1,0,0,8,1,3,3,1,1,0,0,0));
    cfg(3, 5, 1, 64'h5000_0000);
    rule(6, 64'h8000_0000, 64'h9000_0000, mk(0,0,0,1,1,0,0,1,0,0,0,0));
    rule(7, 64'h0, 64'h20_0000, mk(1,0,0,1,1,0,0,1,0,0,0,0));
    cfg(3, 7, 0, 0);
    rule(8, 64'h9000_0000, 64'hA000_0000, mk(1,1,0,2,2,0,0,2,0,1,0,0));
    cfg(3, 8, 0, 64'h9000_0000); cfg(3, 8, 1, 64'h9000_0000);

    single(40'h0000_1000);    // R1: window 0 wins over overlapping window 7
    single(40'h0000_1040);    // R4, R6: index alternates with two channels
    single(40'h0010_0000);    // R5, R8: hash and 4 KB / 256 B granularity
    single(40'h0ABC_DEF0);    // R5
    single(40'h0012_3456);
    single(40'h1500_0000);    // R2
    single(40'h2500_0000);    // R3
    single(40'h3000_0000);    // R7: target 5 is past the channel count
    single(40'h3000_0040);    // R6: channel 1 selected
    single(40'h3000_0080);    // R6: index beyond target count
    single(40'h4800_0000);    // R9: offset underflow
    single(40'h6000_1234);    // R8, R9: 1 GB granularity
    single(40'h8800_0000);    // R1: disabled window
    single(40'hFF_0000_0000); // R1
    single(40'h9000_0040);    // R4, R8: shift-up with 64 B granularity
    single(40'h9000_01C0);
    single(40'h9ABC_DEF0);

    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h04C1_1DB7 : 32'h0);
      step(lfsr[3] | lfsr[5], {9'd0, lfsr[30:0]}, lfsr[7] | lfsr[1]);
    end
    for (int i = 0; i < 20 && expq.size() != 0; i++) step(0, 0, 1);
    check("R11", expq.size(), 0, "requests left unanswered");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule